// File: doc/BRIEF.md
# Locked Vertex Accumulate Pipeline

This block is the gather-side engine for one slice of a partitioned graph. A slice owns a fixed, power-of-two run of vertex indices. The attribute of each vertex in the slice sits in a small on-chip buffer, which a separate load port fills before work starts. Updates arrive as a destination index and a value. Each update that targets the current slice is added to the attribute of its destination vertex, in a three-stage pipeline: fetch, sum, store.

Two updates to the same vertex must never overlap in the pipeline, because the second would fetch a stale value. A lock table holds one bit per local vertex. The bit is set when an update enters and cleared when its result is stored. An update whose vertex is locked is held at the input until the lock drops. Updates to different vertices flow at one per cycle. Starting a new slice selects the slice number, clears every lock, discards work in flight and clears the error flag. A combinational read port returns the buffer contents.

Top module: `vap_engine`

## Requirements
- R1: After reset, `upd_ready_o` is 1, `range_err_o` is 0 and no vertex is locked.
- R2: An accepted in-slice update replaces the attribute at its local address with the old attribute plus the update value, modulo 2^32.
- R3: The local address is `upd_dst_i` minus slice×2^AW, which is the low AW bits. An update is in the slice when its upper IDX_W−AW bits equal the slice number. An out-of-slice update is accepted without stalling and changes no attribute. It sets `range_err_o` in the cycle after acceptance, and `range_err_o` then stays 1 until the next slice start.
- R4: Accepting an in-slice update locks its vertex. While the destination of the update waiting at the input is locked, `upd_ready_o` is 0.
- R5: The lock of a vertex is cleared at the clock edge that stores its result, three edges after acceptance. A second update to the same vertex that is presented right after the first is accepted therefore waits exactly 3 cycles with `upd_ready_o` low. The cleared lock grants a new acceptance only in the following cycle.
- R6: Updates to distinct unlocked vertices are accepted in consecutive cycles with no stall.
- R7: A cycle with `part_start_i` high loads the slice number, clears all locks, drops every update in flight (none is stored) and clears `range_err_o`. `upd_ready_o` is 0 in that cycle.
- R8: `load_en_i` writes `load_data_i` to the local address `load_addr_i` at the clock edge. `rd_data_o` shows the attribute at `rd_addr_i` without delay.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| part_start_i | input | 1 | Start a new slice |
| part_idx_i | input | IDX_W-AW | Slice number, taken when a slice starts |
| load_en_i | input | 1 | Buffer load strobe |
| load_addr_i | input | AW | Buffer load local address |
| load_data_i | input | 32 | Buffer load data |
| upd_valid_i | input | 1 | Update presented |
| upd_dst_i | input | IDX_W | Update destination vertex index |
| upd_val_i | input | 32 | Update value |
| upd_ready_o | output | 1 | Update accepted this cycle when valid |
| range_err_o | output | 1 | Sticky out-of-slice flag |
| rd_addr_i | input | AW | Read port local address |
| rd_data_o | output | 32 | Read port attribute |

## Verification
The assertions check, on every cycle, the locking invariants. They confirm that no accepted update shares a vertex with any update in flight, that the number of set locks equals the number of occupied stages, and that a store clears its lock. They also check that the error flag is sticky, that a slice start empties the locks and the stages, and that out-of-slice updates never enter the pipeline. The arithmetic result, the exact stall length for a repeated vertex and the loss of flushed updates show up only in buffer contents and ready timing. The bench scenarios measure these through the read port and through wait counts.

// File: rtl/vap_pkg.sv
package vap_pkg;
  localparam int unsigned ATTR_W = 32;
  localparam int unsigned PIPE_STAGES = 3;

  typedef logic [ATTR_W-1:0] attr_t;

  function automatic attr_t attr_apply(attr_t old_v, attr_t upd_v);
    return old_v + upd_v;
  endfunction
endpackage

// File: rtl/vap_lock_table.sv
module vap_lock_table #(
  parameter int unsigned AW = 4
) (
  input  logic                clk_i,
  input  logic                rst_ni,
  input  logic                clr_all_i,
  input  logic                set_en_i,
  input  logic [AW-1:0]       set_addr_i,
  input  logic                clr_en_i,
  input  logic [AW-1:0]       clr_addr_i,
  output logic [(1<<AW)-1:0]  lock_o
);
  localparam int unsigned DEPTH = 1 << AW;

  for (genvar g = 0; g < DEPTH; g++) begin : g_lock
    logic lock_q;
    // clear wins over set on the same bit
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni)                                   lock_q <= 1'b0;
      else if (clr_all_i)                            lock_q <= 1'b0;
      else if (clr_en_i && clr_addr_i == AW'(g))     lock_q <= 1'b0;
      else if (set_en_i && set_addr_i == AW'(g))     lock_q <= 1'b1;
    end
    assign lock_o[g] = lock_q;
  end
endmodule

// File: rtl/vap_interval_buf.sv
module vap_interval_buf import vap_pkg::*; #(
  parameter int unsigned AW = 4
) (
  input  logic          clk_i,
  input  logic          ld_en_i,
  input  logic [AW-1:0] ld_addr_i,
  input  attr_t         ld_data_i,
  input  logic          wr_en_i,
  input  logic [AW-1:0] wr_addr_i,
  input  attr_t         wr_data_i,
  input  logic [AW-1:0] rd_a_addr_i,
  output attr_t         rd_a_data_o,
  input  logic [AW-1:0] rd_b_addr_i,
  output attr_t         rd_b_data_o
);
  localparam int unsigned DEPTH = 1 << AW;

  attr_t mem_q [DEPTH];

  // pipeline store overrides a load to the same address
  always_ff @(posedge clk_i) begin
    if (ld_en_i) mem_q[ld_addr_i] <= ld_data_i;
    if (wr_en_i) mem_q[wr_addr_i] <= wr_data_i;
  end

  assign rd_a_data_o = mem_q[rd_a_addr_i];
  assign rd_b_data_o = mem_q[rd_b_addr_i];
endmodule

// File: rtl/vap_apply_pipe.sv
module vap_apply_pipe import vap_pkg::*; #(
  parameter int unsigned AW = 4
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          flush_i,
  input  logic          in_en_i,
  input  logic [AW-1:0] in_addr_i,
  input  attr_t         in_val_i,
  output logic [AW-1:0] rd_addr_o,
  input  attr_t         rd_data_i,
  output logic          s1_vld_o,
  output logic [AW-1:0] s1_addr_o,
  output logic          s2_vld_o,
  output logic [AW-1:0] s2_addr_o,
  output logic          wr_en_o,
  output logic [AW-1:0] wr_addr_o,
  output attr_t         wr_data_o
);
  // stage 1: fetch
  logic          s1_vld_q;
  logic [AW-1:0] s1_addr_q;
  attr_t         s1_val_q;
  // stage 2: sum
  logic          s2_vld_q;
  logic [AW-1:0] s2_addr_q;
  attr_t         s2_old_q, s2_val_q;
  // stage 3: store
  logic          s3_vld_q;
  logic [AW-1:0] s3_addr_q;
  attr_t         s3_data_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      s1_vld_q <= 1'b0;
      s2_vld_q <= 1'b0;
      s3_vld_q <= 1'b0;
    end else if (flush_i) begin
      s1_vld_q <= 1'b0;
      s2_vld_q <= 1'b0;
      s3_vld_q <= 1'b0;
    end else begin
      s1_vld_q <= in_en_i;
      s2_vld_q <= s1_vld_q;
      s3_vld_q <= s2_vld_q;
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      s1_addr_q <= '0;
      s1_val_q  <= '0;
      s2_addr_q <= '0;
      s2_old_q  <= '0;
      s2_val_q  <= '0;
      s3_addr_q <= '0;
      s3_data_q <= '0;
    end else begin
      s1_addr_q <= in_addr_i;
      s1_val_q  <= in_val_i;
      s2_addr_q <= s1_addr_q;
      s2_old_q  <= rd_data_i;
      s2_val_q  <= s1_val_q;
      s3_addr_q <= s2_addr_q;
      s3_data_q <= attr_apply(s2_old_q, s2_val_q);
    end
  end

  assign rd_addr_o = s1_addr_q;
  assign s1_vld_o  = s1_vld_q;
  assign s1_addr_o = s1_addr_q;
  assign s2_vld_o  = s2_vld_q;
  assign s2_addr_o = s2_addr_q;
  assign wr_en_o   = s3_vld_q;
  assign wr_addr_o = s3_addr_q;
  assign wr_data_o = s3_data_q;
endmodule

// File: rtl/vap_engine.sv
module vap_engine import vap_pkg::*; #(
  parameter int unsigned IDX_W = 8,
  parameter int unsigned AW    = 4
) (
  input  logic                  clk_i,
  input  logic                  rst_ni,
  input  logic                  part_start_i,
  input  logic [IDX_W-AW-1:0]   part_idx_i,
  input  logic                  load_en_i,
  input  logic [AW-1:0]         load_addr_i,
  input  logic [ATTR_W-1:0]     load_data_i,
  input  logic                  upd_valid_i,
  input  logic [IDX_W-1:0]      upd_dst_i,
  input  logic [ATTR_W-1:0]     upd_val_i,
  output logic                  upd_ready_o,
  output logic                  range_err_o,
  input  logic [AW-1:0]         rd_addr_i,
  output logic [ATTR_W-1:0]     rd_data_o
);
  localparam int unsigned DEPTH  = 1 << AW;
  localparam int unsigned PART_W = IDX_W - AW;

  logic [PART_W-1:0] part_q;
  logic              err_q;
  logic              in_range, acc, drop;
  logic [AW-1:0]     loc_addr;
  logic [DEPTH-1:0]  lock;

  logic          s1_vld, s2_vld, wr_en;
  logic [AW-1:0] s1_addr, s2_addr, wr_addr, pipe_rd_addr;
  attr_t         wr_data, pipe_rd_data;

  assign in_range    = (upd_dst_i[IDX_W-1:AW] == part_q);
  assign loc_addr    = upd_dst_i[AW-1:0];
  assign upd_ready_o = !part_start_i && (!in_range || !lock[loc_addr]);
  assign acc         = upd_valid_i && upd_ready_o && in_range;
  assign drop        = upd_valid_i && upd_ready_o && !in_range;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      part_q <= '0;
      err_q  <= 1'b0;
    end else if (part_start_i) begin
      part_q <= part_idx_i;
      err_q  <= 1'b0;
    end else if (drop) begin
      err_q  <= 1'b1;
    end
  end
  assign range_err_o = err_q;

  vap_lock_table #(.AW(AW)) u_lock (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .clr_all_i  (part_start_i),
    .set_en_i   (acc),
    .set_addr_i (loc_addr),
    .clr_en_i   (wr_en),
    .clr_addr_i (wr_addr),
    .lock_o     (lock)
  );

  vap_apply_pipe #(.AW(AW)) u_pipe (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .flush_i   (part_start_i),
    .in_en_i   (acc),
    .in_addr_i (loc_addr),
    .in_val_i  (upd_val_i),
    .rd_addr_o (pipe_rd_addr),
    .rd_data_i (pipe_rd_data),
    .s1_vld_o  (s1_vld),
    .s1_addr_o (s1_addr),
    .s2_vld_o  (s2_vld),
    .s2_addr_o (s2_addr),
    .wr_en_o   (wr_en),
    .wr_addr_o (wr_addr),
    .wr_data_o (wr_data)
  );

  vap_interval_buf #(.AW(AW)) u_buf (
    .clk_i       (clk_i),
    .ld_en_i     (load_en_i),
    .ld_addr_i   (load_addr_i),
    .ld_data_i   (load_data_i),
    .wr_en_i     (wr_en),
    .wr_addr_i   (wr_addr),
    .wr_data_i   (wr_data),
    .rd_a_addr_i (pipe_rd_addr),
    .rd_a_data_o (pipe_rd_data),
    .rd_b_addr_i (rd_addr_i),
    .rd_b_data_o (rd_data_o)
  );
endmodule

// File: rtl/vap_chk.sv
module vap_chk #(
  parameter int unsigned AW = 4
) (
  input logic                clk_i,
  input logic                rst_ni,
  input logic                part_start_i,
  input logic                upd_valid_i,
  input logic                upd_ready_i,
  input logic                in_range_i,
  input logic                acc_i,
  input logic [AW-1:0]       acc_addr_i,
  input logic [(1<<AW)-1:0]  lock_i,
  input logic                s1_vld_i,
  input logic [AW-1:0]       s1_addr_i,
  input logic                s2_vld_i,
  input logic [AW-1:0]       s2_addr_i,
  input logic                s3_vld_i,
  input logic [AW-1:0]       s3_addr_i,
  input logic                err_i
);
  AST_NO_RAW_OVERLAP: assert property (@(posedge clk_i) disable iff (!rst_ni)
    acc_i |-> !(s1_vld_i && s1_addr_i == acc_addr_i) && !(s2_vld_i && s2_addr_i == acc_addr_i)
              && !(s3_vld_i && s3_addr_i == acc_addr_i)); // R4

  AST_LOCK_COUNT: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $countones(lock_i) == (int'(s1_vld_i) + int'(s2_vld_i) + int'(s3_vld_i))); // R4

  AST_STORE_UNLOCKS: assert property (@(posedge clk_i) disable iff (!rst_ni)
    s3_vld_i |=> !lock_i[$past(s3_addr_i)]); // R5

  AST_ERR_STICKY: assert property (@(posedge clk_i) disable iff (!rst_ni)
    err_i && !part_start_i |=> err_i); // R3

  AST_OUT_NOT_ISSUED: assert property (@(posedge clk_i) disable iff (!rst_ni)
    upd_valid_i && upd_ready_i && !in_range_i |=> !s1_vld_i && err_i); // R3

  AST_START_EMPTIES: assert property (@(posedge clk_i) disable iff (!rst_ni)
    part_start_i |=> lock_i == '0 && !err_i && !s1_vld_i && !s2_vld_i && !s3_vld_i); // R7

  AST_STAGE_ADVANCE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    s1_vld_i && !part_start_i |=> s2_vld_i && s2_addr_i == $past(s1_addr_i)); // R2
endmodule

bind vap_engine vap_chk #(.AW(AW)) u_chk (
  .clk_i        (clk_i),
  .rst_ni       (rst_ni),
  .part_start_i (part_start_i),
  .upd_valid_i  (upd_valid_i),
  .upd_ready_i  (upd_ready_o),
  .in_range_i   (in_range),
  .acc_i        (acc),
  .acc_addr_i   (loc_addr),
  .lock_i       (lock),
  .s1_vld_i     (s1_vld),
  .s1_addr_i    (s1_addr),
  .s2_vld_i     (s2_vld),
  .s2_addr_i    (s2_addr),
  .s3_vld_i     (wr_en),
  .s3_addr_i    (wr_addr),
  .err_i        (range_err_o)
);

// File: tb/vap_engine_tb.sv
`timescale 1ns/1ps
module vap_engine_tb;
  localparam int unsigned IDX_W = 8;
  localparam int unsigned AW    = 4;
  localparam int unsigned DEPTH = 1 << AW;
  localparam int unsigned NVEC  = 10;

  // {dst, value, expected wait cycles}, slice 2 covers 32..47
  localparam logic [47:0] VEC [NVEC] = '{
    {8'd32, 32'd5,          8'd0},
    {8'd33, 32'd7,          8'd0},
    {8'd32, 32'd1,          8'd2},
    {8'd47, 32'd3,          8'd0},
    {8'd33, 32'hFFFF_FFFF,  8'd0},
    {8'd50, 32'd999,        8'd0},
    {8'd40, 32'd10,         8'd0},
    {8'd40, 32'd20,         8'd3},
    {8'd40, 32'd30,         8'd3},
    {8'd31, 32'd777,        8'd0}
  };

  logic clk_i = 1'b0, rst_ni = 1'b0;
  logic part_start_i = 1'b0;
  logic [IDX_W-AW-1:0] part_idx_i = '0;
  logic load_en_i = 1'b0;
  logic [AW-1:0] load_addr_i = '0;
  logic [31:0] load_data_i = '0;
  logic upd_valid_i = 1'b0;
  logic [IDX_W-1:0] upd_dst_i = '0;
  logic [31:0] upd_val_i = '0;
  logic upd_ready_o, range_err_o;
  logic [AW-1:0] rd_addr_i = '0;
  logic [31:0] rd_data_o;

  int n_chk = 0, n_bad = 0;
  bit done = 1'b0;
  logic [31:0] exp_mem [DEPTH];
  logic [3:0]  cur_part;

  always #2.5 clk_i = ~clk_i;

  vap_engine #(.IDX_W(IDX_W), .AW(AW)) u_dut (.*);

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  // called and returns at posedge+1
  task automatic send(input logic [7:0] d, input logic [31:0] v, output int waited);
    upd_valid_i = 1'b1; upd_dst_i = d; upd_val_i = v; waited = 0;
    #1;
    while (!upd_ready_o) begin
      @(posedge clk_i); #1; waited++;
    end
    @(posedge clk_i); #1;
    upd_valid_i = 1'b0;
    if (d[7:4] == cur_part) exp_mem[d[3:0]] = exp_mem[d[3:0]] + v;
  endtask

  task automatic start_part(input logic [3:0] p);
    part_start_i = 1'b1; part_idx_i = p; #1;
    check("R7 ready low on start", 32'(upd_ready_o), 32'd0);
    @(posedge clk_i); #1;
    part_start_i = 1'b0; cur_part = p;
  endtask

  task automatic settle();
    repeat (6) @(posedge clk_i);
    #1;
  endtask

  task automatic read_all(input string req);
    for (int i = 0; i < DEPTH; i++) begin
      rd_addr_i = AW'(i); #1;
      check(req, rd_data_o, exp_mem[i]);
    end
  endtask

  initial begin
    int w;
    cur_part = 4'd0;
    repeat (3) @(posedge clk_i);
    #1 rst_ni = 1'b1;
    #1;
    check("R1 ready after reset", 32'(upd_ready_o), 32'd1);
    check("R1 err after reset", 32'(range_err_o), 32'd0);
    @(posedge clk_i); #1;

    // R8 preload
    for (int i = 0; i < DEPTH; i++) begin
      load_en_i = 1'b1; load_addr_i = AW'(i); load_data_i = 32'(100 * i);
      exp_mem[i] = 32'(100 * i);
      @(posedge clk_i); #1;
    end
    load_en_i = 1'b0;
    read_all("R8 preload readback");

    start_part(4'd2);

    // vector walk: R2 R3 R4 R5 R6
    for (int k = 0; k < NVEC; k++) begin
      send(VEC[k][47:40], VEC[k][39:8], w);
      check("R5/R6 wait cycles", 32'(w), 32'(VEC[k][7:0]));
    end
    settle();
    check("R3 sticky range error", 32'(range_err_o), 32'd1);
    read_all("R2/R3 attribute after stream");

    // R7 start clears error
    start_part(4'd0);
    check("R7 err cleared", 32'(range_err_o), 32'd0);

    // R6 distinct vertices back to back
    send(8'd0, 32'd1, w);
    send(8'd1, 32'd1, w);
    check("R6 distinct no stall", 32'(w), 32'd0);
    // R5 same vertex stalls three cycles
    send(8'd3, 32'd2, w);
    send(8'd3, 32'd2, w);
    check("R5 same vertex wait", 32'(w), 32'd3);
    settle();

    // R7 flush: update in flight is dropped
    upd_valid_i = 1'b1; upd_dst_i = 8'd5; upd_val_i = 32'd9;
    @(posedge clk_i); #1;
    upd_valid_i = 1'b0;
    start_part(4'd0);
    settle();
    rd_addr_i = 4'd5; #1;
    check("R7 flushed update not stored", rd_data_o, exp_mem[5]);
    read_all("R2 final contents");

    done = 1'b1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

  initial begin
    #100000;
    if (!done) begin
      n_chk++; n_bad++;
      $display("FAIL watchdog: actual hung expected done");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
    end
  end
endmodule